// File: doc/BRIEF.md
# Differential PSK Passband Modulator

This block converts a serial bit stream into real-valued passband samples for a single DAC channel. Bits arrive one per clock through a valid/ready handshake. They are packed into symbols of two bits (differential QPSK) or three bits (differential 8-PSK), with the mode chosen at packet start. Each symbol advances a carrier phase accumulator by a Gray-coded step. The data sits in the phase changes between symbols, so a receiver needs no absolute phase reference.

The carrier runs at exactly one tenth of the sample rate, and every symbol occupies one full carrier cycle of ten samples. In-phase and quadrature amplitudes come from the accumulated phase. They are multiplied by a cosine carrier and by a copy of it advanced by a quarter period, and the two products are summed into one signed 14-bit sample per clock. A packet has a fixed number of output samples. A start pulse opens the packet with one phase-zero reference cycle. After the last sample the block raises a done flag and waits for the next start.

Top module: `dpsk_passband_mod`

## Requirements
- R1: `in_ready` is low out of reset, low between packets, and low inside a packet while a complete symbol waits to be used. The first bit accepted for a symbol becomes its most significant bit.
- R2: With `mode_sel`=0, each 2-bit symbol advances the phase by k·π/2, where k is 0, 1, 2, 3 for codes 00, 01, 11, 10.
- R3: With `mode_sel`=1, each 3-bit symbol advances the phase by k·π/4, where k is 0..7 for codes 000, 001, 011, 010, 110, 111, 101, 100.
- R4: The first ten-sample cycle of a packet carries phase 0 and uses no data. Cycle j (j≥1) carries the phase of cycle j−1 plus the step of the j-th symbol.
- R5: Output sample n of a packet lies within 12 LSB of 4092·cos(2π·(n mod 10)/10 + φ), where φ is the phase of cycle floor(n/10). This equals I·cos(ωt) + Q·cos(ωt+π/2) with I=cos φ and Q=sin φ.
- R6: A start pulse sampled at clock edge e0 makes the first `out_valid` sample appear after edge e2. `out_valid` is still low after e1.
- R7: If no full symbol is buffered at the end of a cycle, the next cycle repeats the previous phase, and `out_underrun` is high for every sample of that cycle. Otherwise `out_underrun` is low.
- R8: A packet delivers exactly PKT_LEN consecutive valid samples. `done` rises the cycle after the last one and stays high until the next accepted start.
- R9: A change of `mode_sel` during a packet does not change the symbol size or step mapping of that packet.
- R10: A start pulse while a packet is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one output sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a packet (accepted when idle) |
| mode_sel | input | 1 | 0: 2-bit differential QPSK, 1: 3-bit differential 8-PSK |
| in_valid | input | 1 | Bit on `in_bit` is valid |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Block accepts a bit this cycle |
| out_sample | output | 14 | Signed passband sample |
| out_valid | output | 1 | `out_sample` holds a packet sample |
| out_underrun | output | 1 | Current sample's cycle repeated the previous phase for lack of data |
| done | output | 1 | Packet complete, held until next start |

## Verification
Directed packets cycle through every Gray code of each mode in turn. A wrong entry in either step table then shows up as a phase error in a known cycle, separate from accumulation errors. Random bit streams in both modes test the accumulation over many cycles against a floating-point cosine reference. A starved packet, which gets only two symbols, separates the hold-and-flag path from normal stepping. Packets that toggle `mode_sel` or pulse `start` mid-stream show whether those inputs are latched and ignored as required, rather than acting at once.

// File: rtl/dpsk_mod_pkg.sv
package dpsk_mod_pkg;

  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_OCT  = 1'b1
  } psk_mode_e;

  // Carrier grid: 40 points per cycle so a quarter period is an integer step
  localparam int GRID_PTS = 40;
  localparam int GRID_QTR = GRID_PTS / 4;
  localparam int GRID_PH  = GRID_PTS / 8;

  function automatic logic [2:0] gray_to_bin(input logic [2:0] g);
    gray_to_bin = {g[2], g[2] ^ g[1], g[2] ^ g[1] ^ g[0]};
  endfunction

  // Phase step in units of pi/4
  function automatic logic [2:0] phase_step(input psk_mode_e m, input logic [2:0] sym);
    logic [2:0] b;
    if (m == MODE_OCT) begin
      b = gray_to_bin(sym);
      phase_step = b;
    end else begin
      b = gray_to_bin({1'b0, sym[1:0]});
      phase_step = {b[1:0], 1'b0};
    end
  endfunction

  // cos(r * 9 deg) scaled to 2047, r in 0..10
  function automatic logic signed [11:0] qtr_cos(input int r);
    case (r)
      0:       qtr_cos = 12'sd2047;
      1:       qtr_cos = 12'sd2022;
      2:       qtr_cos = 12'sd1947;
      3:       qtr_cos = 12'sd1824;
      4:       qtr_cos = 12'sd1656;
      5:       qtr_cos = 12'sd1447;
      6:       qtr_cos = 12'sd1203;
      7:       qtr_cos = 12'sd929;
      8:       qtr_cos = 12'sd633;
      9:       qtr_cos = 12'sd320;
      default: qtr_cos = 12'sd0;
    endcase
  endfunction

  // cos(2*pi*n/40) by quarter-wave symmetry
  function automatic logic signed [11:0] grid_cos(input int n);
    int m;
    int q;
    int r;
    m = n % GRID_PTS;
    q = m / GRID_QTR;
    r = m % GRID_QTR;
    case (q)
      0:       grid_cos = qtr_cos(r);
      1:       grid_cos = -qtr_cos(GRID_QTR - r);
      2:       grid_cos = -qtr_cos(r);
      default: grid_cos = qtr_cos(GRID_QTR - r);
    endcase
  endfunction

endpackage

// File: rtl/dpsk_sym_packer.sv
module dpsk_sym_packer
  import dpsk_mod_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_i,
  input  logic      en_i,
  input  psk_mode_e mode_i,
  input  logic      bit_vld_i,
  input  logic      bit_i,
  input  logic      take_i,
  output logic      ready_o,
  output logic      full_o,
  output logic [2:0] sym_o
);

  logic [2:0] sh_q, sh_d;
  logic [1:0] cnt_q, cnt_d;
  logic [1:0] need;

  always_comb begin
    need    = (mode_i == MODE_OCT) ? 2'd3 : 2'd2;
    full_o  = (cnt_q == need);
    ready_o = en_i && !full_o;
    sym_o   = (mode_i == MODE_OCT) ? sh_q : {1'b0, sh_q[1:0]};
  end

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (take_i) begin
      cnt_d = '0;
    end else if (bit_vld_i && ready_o) begin
      sh_d  = {sh_q[1:0], bit_i};
      cnt_d = cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dpsk_seq_ctrl.sv
module dpsk_seq_ctrl
  import dpsk_mod_pkg::*;
#(
  parameter int SPS     = 10,
  parameter int PKT_LEN = 16777216
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       idle_i,
  input  psk_mode_e                  mode_i,
  input  logic                       full_i,
  input  logic [2:0]                 sym_i,
  output logic                       run_o,
  output psk_mode_e                  mode_o,
  output logic [$clog2(SPS)-1:0]     idx_o,
  output logic [2:0]                 phase_o,
  output logic                       take_o,
  output logic                       und_o,
  output logic                       last_o,
  output logic                       clr_o
);

  localparam int IDX_W = $clog2(SPS);
  localparam int PKT_W = $clog2(PKT_LEN + 1);

  logic             run_q, run_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PKT_W-1:0] pkt_q, pkt_d;
  logic [2:0]       ph_q, ph_d;
  logic             und_q, und_d;
  psk_mode_e        mode_q, mode_d;
  logic             wrap, acc;

  always_comb begin
    wrap   = run_q && (idx_q == IDX_W'(SPS - 1));
    last_o = run_q && (pkt_q == PKT_W'(PKT_LEN - 1));
    acc    = start_i && !run_q && idle_i;
    take_o = wrap && full_i;
    clr_o  = acc;
  end

  always_comb begin
    run_d  = run_q;
    idx_d  = idx_q;
    pkt_d  = pkt_q;
    ph_d   = ph_q;
    und_d  = und_q;
    mode_d = mode_q;
    if (acc) begin
      run_d  = 1'b1;
      idx_d  = '0;
      pkt_d  = '0;
      ph_d   = '0;
      und_d  = 1'b0;
      mode_d = mode_i;
    end else if (run_q) begin
      pkt_d = pkt_q + PKT_W'(1);
      if (last_o) run_d = 1'b0;
      if (wrap) begin
        idx_d = '0;
        if (full_i) begin
          ph_d  = ph_q + phase_step(mode_q, sym_i);
          und_d = 1'b0;
        end else begin
          und_d = 1'b1;
        end
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      pkt_q  <= '0;
      ph_q   <= '0;
      und_q  <= 1'b0;
      mode_q <= MODE_QUAD;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      pkt_q  <= pkt_d;
      ph_q   <= ph_d;
      und_q  <= und_d;
      mode_q <= mode_d;
    end
  end

  assign run_o   = run_q;
  assign mode_o  = mode_q;
  assign idx_o   = idx_q;
  assign phase_o = ph_q;
  assign und_o   = und_q;

endmodule

// File: rtl/dpsk_iq_mixer.sv
module dpsk_iq_mixer
  import dpsk_mod_pkg::*;
#(
  parameter int SPS   = 10,
  parameter int OUT_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic                    last_i,
  input  logic                    und_i,
  input  logic [$clog2(SPS)-1:0]  idx_i,
  input  logic [2:0]              phase_i,
  output logic signed [OUT_W-1:0] smp_o,
  output logic                    vld_o,
  output logic                    last_o,
  output logic                    und_o,
  output logic                    busy_o
);

  localparam int STEP  = GRID_PTS / SPS;
  localparam int ACC_W = 25;
  localparam int SHIFT = 10;
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [11:0] ci_d, cq_d, ia_d, qa_d;
  logic signed [11:0] ci_q, cq_q, ia_q, qa_q;
  logic               v1_q, l1_q, u1_q;
  logic               v2_q, l2_q, u2_q;
  logic signed [ACC_W-1:0] pa, pb, mac, scl;
  logic signed [OUT_W-1:0] sat_d, smp_q;

  // stage 1: carrier and constellation lookups
  always_comb begin
    ci_d = grid_cos(int'(idx_i) * STEP);
    cq_d = grid_cos(int'(idx_i) * STEP + GRID_QTR);
    ia_d = grid_cos(GRID_PH * int'(phase_i));
    qa_d = grid_cos(GRID_PTS + GRID_QTR - GRID_PH * int'(phase_i));
  end

  // stage 2: mix, scale, saturate
  always_comb begin
    pa  = ia_q * ci_q;
    pb  = qa_q * cq_q;
    mac = pa + pb;
    scl = mac >>> SHIFT;
    if (scl > MAXV)      sat_d = MAXV[OUT_W-1:0];
    else if (scl < MINV) sat_d = MINV[OUT_W-1:0];
    else                 sat_d = scl[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ci_q  <= '0;
      cq_q  <= '0;
      ia_q  <= '0;
      qa_q  <= '0;
      v1_q  <= 1'b0;
      l1_q  <= 1'b0;
      u1_q  <= 1'b0;
      v2_q  <= 1'b0;
      l2_q  <= 1'b0;
      u2_q  <= 1'b0;
      smp_q <= '0;
    end else begin
      v1_q <= vld_i;
      l1_q <= vld_i && last_i;
      u1_q <= vld_i && und_i;
      if (vld_i) begin
        ci_q <= ci_d;
        cq_q <= cq_d;
        ia_q <= ia_d;
        qa_q <= qa_d;
      end
      v2_q <= v1_q;
      l2_q <= v1_q && l1_q;
      u2_q <= v1_q && u1_q;
      if (v1_q) smp_q <= sat_d;
    end
  end

  assign smp_o  = smp_q;
  assign vld_o  = v2_q;
  assign last_o = l2_q;
  assign und_o  = u2_q;
  assign busy_o = v1_q || v2_q;

endmodule

// File: rtl/dpsk_passband_mod.sv
module dpsk_passband_mod
  import dpsk_mod_pkg::*;
#(
  parameter int SPS     = 10,
  parameter int PKT_LEN = 16777216,
  parameter int OUT_W   = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    mode_sel,
  input  logic                    in_valid,
  input  logic                    in_bit,
  output logic                    in_ready,
  output logic signed [OUT_W-1:0] out_sample,
  output logic                    out_valid,
  output logic                    out_underrun,
  output logic                    done
);

  localparam int IDX_W = $clog2(SPS);

  logic             run, take, seq_und, seq_last, clr;
  logic             sym_full, m_vld, m_last, m_busy;
  logic [2:0]       sym, seq_phase;
  logic [IDX_W-1:0] seq_idx;
  psk_mode_e        mode_q;
  logic             done_q, done_d;

  dpsk_seq_ctrl #(.SPS(SPS), .PKT_LEN(PKT_LEN)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .idle_i  (!m_busy),
    .mode_i  (psk_mode_e'(mode_sel)),
    .full_i  (sym_full),
    .sym_i   (sym),
    .run_o   (run),
    .mode_o  (mode_q),
    .idx_o   (seq_idx),
    .phase_o (seq_phase),
    .take_o  (take),
    .und_o   (seq_und),
    .last_o  (seq_last),
    .clr_o   (clr)
  );

  dpsk_sym_packer u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .en_i      (run),
    .mode_i    (mode_q),
    .bit_vld_i (in_valid),
    .bit_i     (in_bit),
    .take_i    (take),
    .ready_o   (in_ready),
    .full_o    (sym_full),
    .sym_o     (sym)
  );

  dpsk_iq_mixer #(.SPS(SPS), .OUT_W(OUT_W)) u_mix (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_i   (run),
    .last_i  (seq_last),
    .und_i   (seq_und),
    .idx_i   (seq_idx),
    .phase_i (seq_phase),
    .smp_o   (out_sample),
    .vld_o   (m_vld),
    .last_o  (m_last),
    .und_o   (out_underrun),
    .busy_o  (m_busy)
  );

  always_comb begin
    done_d = done_q;
    if (clr)                  done_d = 1'b0;
    else if (m_vld && m_last) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign out_valid = m_vld;
  assign done      = done_q;

endmodule

// File: rtl/dpsk_mod_chk.sv
module dpsk_mod_chk #(
  parameter int SPS     = 10,
  parameter int PKT_LEN = 16777216
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_underrun,
  input logic                   done,
  input logic                   run_i,
  input logic                   mode_i,
  input logic [$clog2(SPS)-1:0] idx_i,
  input logic [2:0]             phase_i
);

  int unsigned vcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vcnt_q <= 0;
    else if (out_valid) vcnt_q <= vcnt_q + 1;
    else                vcnt_q <= 0;
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && idx_i != '0) |-> (phase_i == $past(phase_i)));

  // R7
  underrun_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_underrun |-> out_valid);

  // R8
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (vcnt_q == PKT_LEN));

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!out_valid && $past(out_valid)));

  // R9
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i)) |-> $stable(mode_i));

endmodule

bind dpsk_passband_mod dpsk_mod_chk #(.SPS(SPS), .PKT_LEN(PKT_LEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_underrun (out_underrun),
  .done         (done),
  .run_i        (run),
  .mode_i       (mode_q),
  .idx_i        (seq_idx),
  .phase_i      (seq_phase)
);

// File: tb/dpsk_passband_mod_bench.sv
module dpsk_passband_mod_bench;

  localparam int  CLK_PERIOD = 10;
  localparam int  SPS        = 10;
  localparam int  PKT        = 120;
  localparam real AMP        = 4092.0;
  localparam real TOL        = 12.0;
  localparam real PI         = 3.14159265358979;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              mode_sel = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_bit = 1'b0;
  logic              in_ready;
  logic signed [13:0] out_sample;
  logic              out_valid;
  logic              out_underrun;
  logic              done;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  int  nav = 0;
  logic pat [0:511];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dpsk_passband_mod #(.SPS(SPS), .PKT_LEN(PKT), .OUT_W(14)) u_dpsk_passband_mod (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode_sel     (mode_sel),
    .in_valid     (in_valid),
    .in_bit       (in_bit),
    .in_ready     (in_ready),
    .out_sample   (out_sample),
    .out_valid    (out_valid),
    .out_underrun (out_underrun),
    .done         (done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected step in units of pi/4, from the Gray code tables of R2 and R3
  function automatic int ref_step(input bit oct, input int code);
    if (!oct) begin
      case (code)
        0: return 0;
        1: return 2;
        3: return 4;
        default: return 6;
      endcase
    end
    case (code)
      0: return 0;
      1: return 1;
      3: return 2;
      2: return 3;
      6: return 4;
      7: return 5;
      5: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic run_packet(input bit oct, input bit toggle_mode, input bit restart_mid,
                            input string tag);
    int nb;
    int nsym;
    int fidx;
    int hs;
    int ocnt;
    int first;
    bit seen_done;
    int phs [0:63];
    nb = oct ? 3 : 2;
    nsym = nav / nb;
    phs[0] = 0;
    for (int j = 1; j < 64; j++) begin
      if (j <= nsym) begin
        int code = 0;
        for (int b = 0; b < nb; b++) code = (code << 1) | int'(pat[(j - 1) * nb + b]);
        phs[j] = (phs[j - 1] + ref_step(oct, code)) % 8;
      end else begin
        phs[j] = phs[j - 1];
      end
    end
    fidx = 0; hs = 0; ocnt = 0; first = -1; seen_done = 0;
    @(negedge clk);
    mode_sel = oct;
    start = 1'b1;
    for (int it = 1; it <= PKT + 40 && !seen_done; it++) begin
      @(negedge clk);
      start = restart_mid && (it == 50);
      fidx += hs;
      if (out_valid) begin
        int k = ocnt % SPS;
        int j = ocnt / SPS;
        real ex = AMP * $cos(2.0 * PI * real'(k) / real'(SPS) + real'(phs[j]) * PI / 4.0);
        real df = real'(int'(out_sample)) - ex;
        bit eu = (j >= 1) && (j > nsym);
        if (first < 0) first = it;
        // R5 with R4 and the mapping of the mode under test
        chk(df <= TOL && df >= -TOL, {"R5 ", tag}, int'(out_sample), $rtoi(ex));
        // R7
        chk(out_underrun == eu, {"R7 ", tag}, int'(out_underrun), int'(eu));
        ocnt++;
      end
      if (done) seen_done = 1;
      if (toggle_mode && it == 40) mode_sel = !oct;
      in_valid = (fidx < nav);
      in_bit = (fidx < nav) ? pat[fidx] : 1'b0;
      hs = int'(in_valid && in_ready);
    end
    in_valid = 1'b0;
    // R6
    chk(first == 3, {"R6 ", tag}, first, 3);
    // R8 / R10
    chk(ocnt == PKT, {"R8 R10 ", tag}, ocnt, PKT);
    chk(seen_done, {"R8 ", tag}, int'(seen_done), 1);
    repeat (5) @(negedge clk);
    // R8 done holds; R1 ready low between packets
    chk(done == 1'b1, {"R8 ", tag}, int'(done), 1);
    chk(in_ready == 1'b0, {"R1 ", tag}, int'(in_ready), 0);
    mode_sel = 1'b0;
  endtask

  task automatic fill_random(input int n);
    nav = n;
    for (int i = 0; i < n; i++) pat[i] = 1'($urandom_range(0, 1));
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4177);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b0, "R1 reset", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R8 reset", int'(out_valid), 0);
    chk(done == 1'b0, "R8 reset", int'(done), 0);
    chk(out_underrun == 1'b0, "R7 reset", int'(out_underrun), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b0, "R1 idle", int'(in_ready), 0);

    // R2 directed: codes 00,01,11,10 repeated
    nav = 80;
    for (int s = 0; s < 40; s++) begin
      int c;
      case (s % 4)
        0: c = 0;
        1: c = 1;
        2: c = 3;
        default: c = 2;
      endcase
      pat[2 * s]     = 1'(c >> 1);
      pat[2 * s + 1] = 1'(c);
    end
    run_packet(1'b0, 1'b0, 1'b0, "R2 quad-gray");

    // R3 directed: all eight codes in order
    nav = 120;
    for (int s = 0; s < 40; s++) begin
      pat[3 * s]     = 1'((s % 8) >> 2);
      pat[3 * s + 1] = 1'((s % 8) >> 1);
      pat[3 * s + 2] = 1'(s % 8);
    end
    run_packet(1'b1, 1'b0, 1'b0, "R3 oct-gray");

    // R4 random streams in both modes
    for (int r = 0; r < 2; r++) begin
      fill_random(100);
      run_packet(1'b0, 1'b0, 1'b0, "R4 R2 quad-rand");
      fill_random(150);
      run_packet(1'b1, 1'b0, 1'b0, "R4 R3 oct-rand");
    end

    // R7 starved packet: two symbols only
    fill_random(6);
    run_packet(1'b1, 1'b0, 1'b0, "R7 starve");

    // R9 mode toggled mid-packet
    fill_random(100);
    run_packet(1'b0, 1'b1, 1'b0, "R9 mode-toggle");
    fill_random(150);
    run_packet(1'b1, 1'b1, 1'b0, "R9 mode-toggle8");

    // R10 start pulsed mid-packet
    fill_random(150);
    run_packet(1'b1, 1'b0, 1'b1, "R10 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule